// File: doc/BRIEF.md
# Two-Layer Overlay Window Blender

This block mixes two rectangular overlay layers onto a flat background colour, one pixel at a time, for the visible area of a display frame. A timing generator supplies the current pixel coordinates and a frame-start pulse. The fetch path supplies one pixel for each layer, already converted to RGB. The block returns the mixed colour a fixed number of cycles later. Layer 1 sits on top of layer 0, and layer 0 sits on top of the background.

Each layer has a window (origin, width, height), an enable, a pixel format code and an alpha source. The alpha is either a constant 8-bit coefficient or the alpha byte carried in each pixel. Software writes layer settings into a shadow copy. A commit request marks a layer's shadow copy as ready, and the copy becomes active at the next frame start. This means a frame is never drawn with a half-updated window.

Top module: `twin_layer_mixer`

## Requirements
- R1: After reset, `out_valid`, `out_rgb` and `commit_busy` are all zero, and both layers are inactive until their first commit is applied, so every pixel returns the background.
- R2: A pixel lies inside a layer window when `x0 <= pix_x < x0 + w` and `y0 <= pix_y < y0 + h`. Both lower bounds are inclusive and both upper bounds are exclusive.
- R3: When a layer is disabled, or the pixel lies outside that layer's window, that layer passes the colour from below it through with no change.
- R4: Each channel of a mix is `(a*top + (255-a)*below + 127) / 255`, using integer division. Layer 0 is mixed over the background, then layer 1 is mixed over that result.
- R5: When `cfg_const_alpha` is 1, the layer uses `cfg_alpha` and ignores the pixel's alpha byte. A coefficient of 255 makes the layer fully opaque. When `cfg_const_alpha` is 0, the alpha is taken from pixel bits 31:24.
- R6: Format code 1 means RGB565 in pixel bits 15:0. Each channel is widened to 8 bits by copying its top bits into the freed low bits, and the per-pixel alpha is then 255. Every other format code means ARGB8888, with A in bits 31:24, R in 23:16, G in 15:8 and B in 7:0.
- R7: A shadow write changes nothing at the output until that layer is committed and a frame start has followed. A commit without a frame start also changes nothing at the output.
- R8: `commit_mask` bit 0 selects layer 0 and bit 1 selects layer 1. Setting both bits commits both layers in one write. A selected layer's `commit_busy` bit is 1 from the cycle after the commit until the next frame start, and then clears by itself.
- R9: `out_valid` and `out_rgb` follow a `pix_valid` sample by exactly 5 clock cycles.
- R10: The background colour `bg_rgb` holds R in bits 23:16, G in bits 15:8 and B in bits 7:0. The output uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for one layer's shadow settings |
| cfg_layer | input | 1 | Layer selected by `cfg_wr` |
| cfg_enable | input | 1 | Layer enable |
| cfg_const_alpha | input | 1 | 1 selects the constant coefficient as alpha |
| cfg_alpha | input | 8 | Constant alpha coefficient |
| cfg_format | input | 3 | Pixel format code (1 = RGB565, others = ARGB8888) |
| cfg_x0 | input | 12 | Window horizontal origin |
| cfg_y0 | input | 12 | Window vertical origin |
| cfg_w | input | 12 | Window width |
| cfg_h | input | 12 | Window height |
| commit_wr | input | 1 | Commit request strobe |
| commit_mask | input | 2 | Layers to commit (bit 0 = layer 0, bit 1 = layer 1) |
| commit_busy | output | 2 | Commit pending, one bit per layer |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| bg_rgb | input | 24 | Background colour |
| pix_valid | input | 1 | Pixel coordinates and layer pixels are valid |
| pix_x | input | 12 | Active-region column |
| pix_y | input | 12 | Active-region row |
| l0_pixel | input | 32 | Layer 0 pixel |
| l1_pixel | input | 32 | Layer 1 pixel |
| out_valid | output | 1 | Mixed pixel valid |
| out_rgb | output | 24 | Mixed pixel colour |

## Verification
An active window that is wrong, or a commit that is lost, shows at the ports in two ways. The pixels on the window edges come out as the background when they should be the layer colour, or the reverse. An unexpected `commit_busy` value also appears one cycle after the commit or frame start. A fault in the mix arithmetic or the alpha selection shows as a one-off colour error five cycles after the pixel that caused it. A fault in the pipeline timing shows as `out_valid` arriving one cycle early or late. For these reasons the bench samples the first and last pixels inside each window, and the pixels just outside each edge. It also uses mixes where the rounding matters.

// File: rtl/twin_layer_pkg.sv
// Shared widths, the per-layer settings record and the RGB565 widening
// function for the two-layer mixer. Assumes 8-bit channels and 12-bit
// coordinates throughout.
package twin_layer_pkg;

    localparam int POS_W    = 12;
    localparam int CH_W     = 8;
    localparam int N_CH     = 3;
    localparam int RGB_W    = CH_W * N_CH;
    localparam int PIX_W    = 32;
    localparam int FMT_W    = 3;
    localparam int N_LAYERS = 2;
    localparam logic [FMT_W-1:0] FMT_RGB565 = 3'd1;

    typedef struct packed {
        logic             enable;
        logic             const_alpha;
        logic [CH_W-1:0]  alpha;
        logic [FMT_W-1:0] format;
        logic [POS_W-1:0] x0;
        logic [POS_W-1:0] y0;
        logic [POS_W-1:0] w;
        logic [POS_W-1:0] h;
    } layer_cfg_t;

    // Widen a 5-6-5 pixel to 8 bits per channel by bit replication.
    function automatic logic [RGB_W-1:0] widen_565(input logic [15:0] p);
        logic [4:0] r5;
        logic [5:0] g6;
        logic [4:0] b5;
        r5 = p[15:11];
        g6 = p[10:5];
        b5 = p[4:0];
        return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
    endfunction

endpackage

// File: rtl/layer_cfg_bank.sv
// Shadow and active settings for one layer. Writes land in the shadow
// copy; a commit marks it pending; the next frame start copies shadow to
// active and clears the pending flag. A commit arriving in the same cycle
// as a frame start stays pending for the following frame.
module layer_cfg_bank
    import twin_layer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  layer_cfg_t wr_cfg,
    input  logic       commit,
    input  logic       frame_start,
    output layer_cfg_t active,
    output logic       pending
);

    layer_cfg_t shadow;

    // Capture software writes into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n)  shadow <= '0;
        else if (wr) shadow <= wr_cfg;
    end

    // Track the commit request: set by commit, cleared by a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending & ~frame_start) | commit;
    end

    // Load the active copy at a frame start when a commit is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                        active <= '0;
        else if (frame_start && pending)   active <= shadow;
    end

endmodule

// File: rtl/layer_front.sv
// Combinational front end for one layer: window hit test, format decode
// and alpha selection. A miss or a disabled layer yields alpha 0, which
// makes the following mix return the lower colour exactly.
module layer_front
    import twin_layer_pkg::*;
(
    input  layer_cfg_t       cfg,
    input  logic [POS_W-1:0] x,
    input  logic [POS_W-1:0] y,
    input  logic [PIX_W-1:0] pix,
    output logic [RGB_W-1:0] rgb,
    output logic [CH_W-1:0]  alpha
);

    logic             in_x;
    logic             in_y;
    logic             is565;
    logic [CH_W-1:0]  pix_alpha;

    // Window test with one extra bit so origin + size cannot wrap.
    always_comb begin
        in_x = ({1'b0, x} >= {1'b0, cfg.x0}) &&
               ({1'b0, x} <  ({1'b0, cfg.x0} + {1'b0, cfg.w}));
        in_y = ({1'b0, y} >= {1'b0, cfg.y0}) &&
               ({1'b0, y} <  ({1'b0, cfg.y0} + {1'b0, cfg.h}));
    end

    // Decode the pixel format and pick the alpha source.
    always_comb begin
        is565     = (cfg.format == FMT_RGB565);
        rgb       = is565 ? widen_565(pix[15:0]) : pix[RGB_W-1:0];
        pix_alpha = is565 ? {CH_W{1'b1}} : pix[PIX_W-1:PIX_W-CH_W];
        if (cfg.enable && in_x && in_y)
            alpha = cfg.const_alpha ? cfg.alpha : pix_alpha;
        else
            alpha = '0;
    end

endmodule

// File: rtl/blend_unit.sv
// Two-stage alpha mixer: stage one forms a*top + (max-a)*below for each
// channel, stage two adds half of max and divides by max. The output
// register loads only for valid samples and otherwise holds.
module blend_unit #(
    parameter int CH_W = 8,
    parameter int N_CH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CH_W-1:0]      alpha,
    input  logic [N_CH*CH_W-1:0] top,
    input  logic [N_CH*CH_W-1:0] below,
    output logic                 out_valid,
    output logic [N_CH*CH_W-1:0] out_pix
);

    localparam int MAXV  = (1 << CH_W) - 1;
    localparam int SUM_W = 2 * CH_W + 1;

    logic             p_valid;
    logic [SUM_W-1:0] p_sum [N_CH];

    // Carry the valid flag through both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_valid   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            p_valid   <= in_valid;
            out_valid <= p_valid;
        end
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        // Stage one: weighted sum of the two colours.
        always_ff @(posedge clk) begin
            if (!rst_n) p_sum[ch] <= '0;
            else        p_sum[ch] <= SUM_W'(alpha) * SUM_W'(top[ch*CH_W +: CH_W]) +
                                     (SUM_W'(MAXV) - SUM_W'(alpha)) * SUM_W'(below[ch*CH_W +: CH_W]);
        end
        // Stage two: rounded division by the full-scale value.
        always_ff @(posedge clk) begin
            if (!rst_n)       out_pix[ch*CH_W +: CH_W] <= '0;
            else if (p_valid) out_pix[ch*CH_W +: CH_W] <=
                                  CH_W'((p_sum[ch] + SUM_W'(MAXV / 2)) / SUM_W'(MAXV));
        end
    end

endmodule

// File: rtl/twin_layer_mixer.sv
// Two-layer overlay mixer. Holds the shadow and active settings of both
// layers, registers the front-end results, mixes layer 0 over the
// background and then layer 1 over that. Latency is 5 cycles from a
// pix_valid sample to out_valid. The timing generator is assumed to give
// one frame_start pulse per frame.
module twin_layer_mixer
    import twin_layer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_layer,
    input  logic                cfg_enable,
    input  logic                cfg_const_alpha,
    input  logic [7:0]          cfg_alpha,
    input  logic [2:0]          cfg_format,
    input  logic [11:0]         cfg_x0,
    input  logic [11:0]         cfg_y0,
    input  logic [11:0]         cfg_w,
    input  logic [11:0]         cfg_h,
    input  logic                commit_wr,
    input  logic [1:0]          commit_mask,
    output logic [1:0]          commit_busy,
    input  logic                frame_start,
    input  logic [23:0]         bg_rgb,
    input  logic                pix_valid,
    input  logic [11:0]         pix_x,
    input  logic [11:0]         pix_y,
    input  logic [31:0]         l0_pixel,
    input  logic [31:0]         l1_pixel,
    output logic                out_valid,
    output logic [23:0]         out_rgb
);

    layer_cfg_t        wr_cfg;
    layer_cfg_t        act_cfg [N_LAYERS];
    logic [PIX_W-1:0]  lay_pix [N_LAYERS];
    logic [RGB_W-1:0]  f_rgb   [N_LAYERS];
    logic [CH_W-1:0]   f_alpha [N_LAYERS];

    logic              s1_valid;
    logic [RGB_W-1:0]  s1_bg;
    logic [RGB_W-1:0]  s1_rgb   [N_LAYERS];
    logic [CH_W-1:0]   s1_alpha [N_LAYERS];

    logic [RGB_W-1:0]  d2_rgb, d3_rgb;
    logic [CH_W-1:0]   d2_alpha, d3_alpha;

    logic              b0_valid;
    logic [RGB_W-1:0]  b0_rgb;

    // Assemble the settings record from the write port.
    always_comb begin
        wr_cfg.enable      = cfg_enable;
        wr_cfg.const_alpha = cfg_const_alpha;
        wr_cfg.alpha       = cfg_alpha;
        wr_cfg.format      = cfg_format;
        wr_cfg.x0          = cfg_x0;
        wr_cfg.y0          = cfg_y0;
        wr_cfg.w           = cfg_w;
        wr_cfg.h           = cfg_h;
    end

    assign lay_pix[0] = l0_pixel;
    assign lay_pix[1] = l1_pixel;

    for (genvar g = 0; g < N_LAYERS; g++) begin : g_layer
        layer_cfg_bank u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr          (cfg_wr && (cfg_layer == 1'(g))),
            .wr_cfg      (wr_cfg),
            .commit      (commit_wr && commit_mask[g]),
            .frame_start (frame_start),
            .active      (act_cfg[g]),
            .pending     (commit_busy[g])
        );

        layer_front u_front (
            .cfg   (act_cfg[g]),
            .x     (pix_x),
            .y     (pix_y),
            .pix   (lay_pix[g]),
            .rgb   (f_rgb[g]),
            .alpha (f_alpha[g])
        );

        // Register the front-end result of this layer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_rgb[g]   <= '0;
                s1_alpha[g] <= '0;
            end else begin
                s1_rgb[g]   <= f_rgb[g];
                s1_alpha[g] <= f_alpha[g];
            end
        end
    end

    // Register the valid flag and the background with the pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_bg    <= '0;
        end else begin
            s1_valid <= pix_valid;
            s1_bg    <= bg_rgb;
        end
    end

    // Delay layer 1 by two cycles to line up with the layer 0 mix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d2_rgb   <= '0;
            d2_alpha <= '0;
            d3_rgb   <= '0;
            d3_alpha <= '0;
        end else begin
            d2_rgb   <= s1_rgb[1];
            d2_alpha <= s1_alpha[1];
            d3_rgb   <= d2_rgb;
            d3_alpha <= d2_alpha;
        end
    end

    blend_unit #(.CH_W(CH_W), .N_CH(N_CH)) u_mix0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s1_valid),
        .alpha     (s1_alpha[0]),
        .top       (s1_rgb[0]),
        .below     (s1_bg),
        .out_valid (b0_valid),
        .out_pix   (b0_rgb)
    );

    blend_unit #(.CH_W(CH_W), .N_CH(N_CH)) u_mix1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (b0_valid),
        .alpha     (d3_alpha),
        .top       (d3_rgb),
        .below     (b0_rgb),
        .out_valid (out_valid),
        .out_pix   (out_rgb)
    );

endmodule

// File: rtl/twin_layer_mixer_chk.sv
// Protocol checker for the two-layer mixer: commit flag behaviour and the
// fixed output latency. A cycle counter since reset keeps the latency
// property away from pre-reset history.
module twin_layer_mixer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       commit_wr,
    input logic [1:0] commit_mask,
    input logic       frame_start,
    input logic [1:0] commit_busy,
    input logic       pix_valid,
    input logic       out_valid
);

    localparam int LAT = 5;

    logic [2:0] since_rst;

    // Count cycles since reset, saturating once the pipeline is full.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst < LAT) since_rst <= since_rst + 3'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && commit_busy == 2'b00));

    p_commit_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_wr |=> ((commit_busy & $past(commit_mask)) == $past(commit_mask)));

    p_frame_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !commit_wr) |=> (commit_busy == 2'b00));

    p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !commit_wr) |=> $stable(commit_busy));

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'(LAT)) |-> (out_valid == $past(pix_valid, 5)));

endmodule

bind twin_layer_mixer twin_layer_mixer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_wr   (commit_wr),
    .commit_mask (commit_mask),
    .frame_start (frame_start),
    .commit_busy (commit_busy),
    .pix_valid   (pix_valid),
    .out_valid   (out_valid)
);

// File: tb/twin_layer_mixer_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, commit timing, formats, alpha sources and latency.
module twin_layer_mixer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr, cfg_layer, cfg_enable, cfg_const_alpha;
    logic [7:0]  cfg_alpha;
    logic [2:0]  cfg_format;
    logic [11:0] cfg_x0, cfg_y0, cfg_w, cfg_h;
    logic        commit_wr;
    logic [1:0]  commit_mask;
    logic [1:0]  commit_busy;
    logic        frame_start;
    logic [23:0] bg_rgb;
    logic        pix_valid;
    logic [11:0] pix_x, pix_y;
    logic [31:0] l0_pixel, l1_pixel;
    logic        out_valid;
    logic [23:0] out_rgb;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    twin_layer_mixer dut_i (.*);

    // {x, y, layer0 pixel, layer1 pixel, expected}; layer0 window 10..29 x
    // 5..12 per-pixel ARGB, layer1 window 20..23 x 6..7 RGB565 const 0x80.
    localparam int NV = 10;
    localparam logic [111:0] VEC [NV] = '{
        {12'd0,  12'd0,  32'hFF112233, 32'h0000F800, 24'h204060},
        {12'd10, 12'd5,  32'hFF112233, 32'h0000F800, 24'h112233},
        {12'd9,  12'd5,  32'hFF112233, 32'h0000F800, 24'h204060},
        {12'd29, 12'd12, 32'h80FF0080, 32'h0000F800, 24'h902070},
        {12'd30, 12'd5,  32'hFFFFFFFF, 32'h0000F800, 24'h204060},
        {12'd10, 12'd13, 32'hFFFFFFFF, 32'h0000F800, 24'h204060},
        {12'd21, 12'd6,  32'hFF112233, 32'h0000F800, 24'h881119},
        {12'd23, 12'd7,  32'h00ABCDEF, 32'h000007E0, 24'h10A030},
        {12'd24, 12'd7,  32'hFF445566, 32'h0000F800, 24'h445566},
        {12'd15, 12'd8,  32'h00FFFFFF, 32'h0000F800, 24'h204060}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic lay, input logic en, input logic ca, input logic [7:0] a,
                             input logic [2:0] fmt, input logic [11:0] x0, input logic [11:0] y0,
                             input logic [11:0] w, input logic [11:0] h);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_layer = lay; cfg_enable = en; cfg_const_alpha = ca;
        cfg_alpha = a; cfg_format = fmt; cfg_x0 = x0; cfg_y0 = y0; cfg_w = w; cfg_h = h;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic commit(input logic [1:0] m);
        @(negedge clk);
        commit_wr = 1'b1; commit_mask = m;
        @(negedge clk);
        commit_wr = 1'b0; commit_mask = 2'b00;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // Drive one pixel and return the output 5 cycles later.
    task automatic run_pixel(input logic [11:0] x, input logic [11:0] y,
                             input logic [31:0] p0, input logic [31:0] p1,
                             output logic v, output logic [23:0] rgb);
        @(negedge clk);
        pix_valid = 1'b1; pix_x = x; pix_y = y; l0_pixel = p0; l1_pixel = p1;
        @(negedge clk);
        pix_valid = 1'b0;
        repeat (4) @(negedge clk);
        v   = out_valid;
        rgb = out_rgb;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic        v;
        logic [23:0] rgb;
        rst_n = 1'b0; cfg_wr = 0; cfg_layer = 0; cfg_enable = 0; cfg_const_alpha = 0;
        cfg_alpha = 0; cfg_format = 0; cfg_x0 = 0; cfg_y0 = 0; cfg_w = 0; cfg_h = 0;
        commit_wr = 0; commit_mask = 0; frame_start = 0; bg_rgb = 24'h204060;
        pix_valid = 0; pix_x = 0; pix_y = 0; l0_pixel = 0; l1_pixel = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports.
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 out_rgb", 32'(out_rgb), 32'd0);
        check("R1 commit_busy", 32'(commit_busy), 32'd0);
        run_pixel(12'd12, 12'd6, 32'hFF112233, 32'hFF445566, v, rgb);
        check("R1 inactive layers give background", 32'(rgb), 32'h204060);

        // R7: shadow writes alone do not reach the output.
        write_cfg(1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 12'd10, 12'd5, 12'd20, 12'd8);
        write_cfg(1'b1, 1'b1, 1'b1, 8'h80, 3'd1, 12'd20, 12'd6, 12'd4, 12'd2);
        run_pixel(12'd12, 12'd6, 32'hFF112233, 32'h0, v, rgb);
        check("R7 uncommitted write ignored", 32'(rgb), 32'h204060);

        // R8: commit both layers in one write.
        commit(2'b11);
        check("R8 busy after dual commit", 32'(commit_busy), 32'd3);
        run_pixel(12'd12, 12'd6, 32'hFF112233, 32'h0, v, rgb);
        check("R7 commit without frame start ignored", 32'(rgb), 32'h204060);
        pulse_frame();
        check("R8 busy clears at frame start", 32'(commit_busy), 32'd0);

        // R2 R3 R4 R5 R6 R10: table walk.
        for (int i = 0; i < NV; i++) begin
            run_pixel(VEC[i][111:100], VEC[i][99:88], VEC[i][87:56], VEC[i][55:24], v, rgb);
            check("R9 out_valid on table pixel", 32'(v), 32'd1);
            check($sformatf("R2/R3/R4 table %0d", i), 32'(rgb), 32'(VEC[i][23:0]));
        end

        // R9: exact latency of out_valid.
        @(negedge clk);
        pix_valid = 1'b1; pix_x = 12'd0; pix_y = 12'd0;
        @(negedge clk);
        pix_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 not valid at 4 cycles", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R9 valid at 5 cycles", 32'(out_valid), 32'd1);
        @(negedge clk);
        check("R9 single-cycle valid", 32'(out_valid), 32'd0);

        // R6: RGB565 widening with per-pixel alpha (opaque).
        write_cfg(1'b1, 1'b1, 1'b0, 8'h00, 3'd1, 12'd20, 12'd6, 12'd4, 12'd2);
        commit(2'b10);
        check("R8 busy only layer1", 32'(commit_busy), 32'd2);
        pulse_frame();
        run_pixel(12'd21, 12'd6, 32'hFF112233, 32'h00008410, v, rgb);
        check("R6 RGB565 widen opaque", 32'(rgb), 32'h848284);

        // R5 R6: constant 255 ignores pixel alpha; code 3 is ARGB8888.
        write_cfg(1'b1, 1'b1, 1'b1, 8'hFF, 3'd3, 12'd20, 12'd6, 12'd4, 12'd2);
        write_cfg(1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 12'd10, 12'd5, 12'd20, 12'd8);
        commit(2'b10);
        pulse_frame();
        run_pixel(12'd21, 12'd6, 32'hFF112233, 32'h00ABCDEF, v, rgb);
        check("R5 constant 255 opaque", 32'(rgb), 32'hABCDEF);

        // R7: layer0 shadow changed but not committed: still active.
        run_pixel(12'd15, 12'd8, 32'hFF123456, 32'h0, v, rgb);
        check("R7 layer0 keeps active settings", 32'(rgb), 32'h123456);
        commit(2'b01);
        check("R8 busy only layer0", 32'(commit_busy), 32'd1);
        run_pixel(12'd15, 12'd8, 32'hFF123456, 32'h0, v, rgb);
        check("R7 pending commit not yet applied", 32'(rgb), 32'h123456);
        pulse_frame();
        check("R8 layer0 busy cleared", 32'(commit_busy), 32'd0);
        run_pixel(12'd15, 12'd8, 32'hFF123456, 32'h0, v, rgb);
        check("R3 disabled layer passes background", 32'(rgb), 32'h204060);

        // R10: background byte layout.
        bg_rgb = 24'hA1B2C3;
        run_pixel(12'd0, 12'd0, 32'h0, 32'h0, v, rgb);
        check("R10 background layout", 32'(rgb), 32'hA1B2C3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule